// File: doc/BRIEF.md
# Segmented Instruction Fetch Address Unit

This unit holds the code segment value and the instruction offset of a small processor front end and turns them into a 20-bit physical fetch address. The address is the segment moved up by four bit positions plus the zero-extended offset. The sum wraps within the 20-bit space.

The unit cycles through three phases: fetch, advance and execute. In fetch it raises a request and presents the address. A completion pulse from memory returns the length of the instruction just read. In advance the offset moves past that instruction. In execute the decoder may redirect the flow. A far jump replaces both segment and offset. A near jump through a register replaces only the offset. Both kinds of jump override the offset that was already advanced. With no jump, the next fetch starts at the advanced offset.

Top module: `seg_fetch_unit`

## Requirements
- R1: While reset is low and right after it, the segment holds parameter RST_SEG and the offset holds RST_OFF. The unit is in the fetch phase, so `fetch_req` is 1, `exec_valid` is 0, and `fetch_addr` is RST_SEG*16+RST_OFF.
- R2: During fetch, `fetch_addr` equals (segment << 4) + offset, taken modulo 2^20. For example, FFFF:0010 gives 0x00000 and FFFF:FFFF gives 0x0FFEF.
- R3: The phases run in a fixed order. `fetch_done` seen in fetch leads to one advance cycle, in which both `fetch_req` and `exec_valid` are 0. Then comes one execute cycle with `exec_valid`=1, and then the unit returns to fetch.
- R4: In the advance cycle the offset grows by the `fetch_len` captured with `fetch_done`. It wraps modulo 2^16 and never carries into the segment, so 1000:FFFE plus 3 gives 1000:0001, at address 0x10001.
- R5: `jmp_far` during execute loads the segment from `jmp_far_seg` and the offset from `jmp_far_off`. After a far jump to 2AE3:0003, the next fetch address is 0x2AE33.
- R6: `jmp_near` (with `jmp_far` low) during execute loads the offset from `jmp_near_off`. The segment is left unchanged.
- R7: When `jmp_far` and `jmp_near` are both high during execute, the far jump wins.
- R8: Jump inputs outside execute are ignored. `fetch_done` and `fetch_len` outside fetch are ignored. While fetch waits, `fetch_addr` stays stable.
- R9: With no jump in execute, the next fetch address is the advanced offset in the current segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_addr | output | SEG_W+SEG_SHIFT | Physical fetch address |
| fetch_req | output | 1 | High in the fetch phase |
| fetch_done | input | 1 | Memory has returned the instruction |
| fetch_len | input | LEN_W | Length in bytes of that instruction |
| exec_valid | output | 1 | High in the execute phase |
| jmp_far | input | 1 | Far jump command |
| jmp_far_seg | input | SEG_W | Far jump segment |
| jmp_far_off | input | OFF_W | Far jump offset |
| jmp_near | input | 1 | Register-indirect near jump command |
| jmp_near_off | input | OFF_W | Near jump offset from the register |

## Verification
The bench uses 16-bit segment and offset, a shift of 4 and a 4-bit length field. This gives the full 20-bit wrap, and lengths up to 15 can push the offset across 0xFFFF from a nearby far-jump target. The reset values are set to 0FFF:0010 rather than the defaults. The first expected address, 0x10000, therefore only matches if the segment shift and the offset addition both work from reset.

// File: rtl/seg_fetch_pkg.sv
package seg_fetch_pkg;
   typedef enum logic [1:0] {
      PH_FETCH   = 2'd0,
      PH_ADVANCE = 2'd1,
      PH_EXEC    = 2'd2
   } phase_e;
endpackage

// File: rtl/sfu_phase_ctrl.sv
module sfu_phase_ctrl
   import seg_fetch_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic fetch_done,
   output logic fetch_req,
   output logic take_len,
   output logic adv_en,
   output logic exec_en
);
   phase_e phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_FETCH;
      end else begin
         case (phase_q)
            PH_FETCH:   if (fetch_done) phase_q <= PH_ADVANCE;
            PH_ADVANCE: phase_q <= PH_EXEC;
            PH_EXEC:    phase_q <= PH_FETCH;
            default:    phase_q <= PH_FETCH;
         endcase
      end
   end

   always_comb begin
      fetch_req = (phase_q == PH_FETCH);
      adv_en    = (phase_q == PH_ADVANCE);
      exec_en   = (phase_q == PH_EXEC);
      take_len  = fetch_req && fetch_done;
   end
endmodule

// File: rtl/sfu_ptr_regs.sv
module sfu_ptr_regs #(
   parameter int unsigned SEG_W   = 16,
   parameter int unsigned OFF_W   = 16,
   parameter int unsigned LEN_W   = 4,
   parameter logic [SEG_W-1:0] RST_SEG = '1,
   parameter logic [OFF_W-1:0] RST_OFF = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_len,
   input  logic [LEN_W-1:0] len_in,
   input  logic             adv_en,
   input  logic             exec_en,
   input  logic             jmp_far,
   input  logic [SEG_W-1:0] far_seg,
   input  logic [OFF_W-1:0] far_off,
   input  logic             jmp_near,
   input  logic [OFF_W-1:0] near_off,
   output logic [SEG_W-1:0] seg_q,
   output logic [OFF_W-1:0] off_q
);
   logic [LEN_W-1:0] len_q;
   logic [OFF_W-1:0] len_ext;

   generate
      if (LEN_W == OFF_W) begin : g_len_full
         assign len_ext = len_q;
      end else begin : g_len_pad
         assign len_ext = {{(OFF_W-LEN_W){1'b0}}, len_q};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_q <= RST_SEG;
         off_q <= RST_OFF;
         len_q <= '0;
      end else begin
         if (take_len) len_q <= len_in;
         if (adv_en) begin
            off_q <= off_q + len_ext;
         end else if (exec_en) begin
            if (jmp_far) begin
               seg_q <= far_seg;
               off_q <= far_off;
            end else if (jmp_near) begin
               off_q <= near_off;
            end
         end
      end
   end
endmodule

// File: rtl/sfu_phys_adder.sv
module sfu_phys_adder #(
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned OFF_W     = 16,
   parameter int unsigned SEG_SHIFT = 4,
   localparam int unsigned PHYS_W   = SEG_W + SEG_SHIFT
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   output logic [PHYS_W-1:0] phys
);
   logic [PHYS_W-1:0] base;
   logic [PHYS_W-1:0] off_ext;

   generate
      if (SEG_SHIFT == 0) begin : g_flat
         assign base = seg;
      end else begin : g_shifted
         assign base = {seg, {SEG_SHIFT{1'b0}}};
      end
      if (OFF_W == PHYS_W) begin : g_off_full
         assign off_ext = off;
      end else begin : g_off_pad
         assign off_ext = {{(PHYS_W-OFF_W){1'b0}}, off};
      end
   endgenerate

   assign phys = base + off_ext;
endmodule

// File: rtl/seg_fetch_unit.sv
module seg_fetch_unit #(
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned OFF_W     = 16,
   parameter int unsigned SEG_SHIFT = 4,
   parameter int unsigned LEN_W     = 4,
   parameter logic [SEG_W-1:0] RST_SEG = '1,
   parameter logic [OFF_W-1:0] RST_OFF = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   output logic [SEG_W+SEG_SHIFT-1:0] fetch_addr,
   output logic                       fetch_req,
   input  logic                       fetch_done,
   input  logic [LEN_W-1:0]           fetch_len,
   output logic                       exec_valid,
   input  logic                       jmp_far,
   input  logic [SEG_W-1:0]           jmp_far_seg,
   input  logic [OFF_W-1:0]           jmp_far_off,
   input  logic                       jmp_near,
   input  logic [OFF_W-1:0]           jmp_near_off
);
   localparam int unsigned PHYS_W = SEG_W + SEG_SHIFT;

   generate
      if (OFF_W > PHYS_W) begin : g_bad_off
         $error("offset wider than physical address");
      end
      if (LEN_W == 0 || LEN_W > OFF_W) begin : g_bad_len
         $error("length field must fit the offset");
      end
      if (SEG_W == 0 || OFF_W == 0) begin : g_bad_w
         $error("segment and offset widths must be nonzero");
      end
   endgenerate

   logic             take_len, adv_en, exec_en;
   logic [SEG_W-1:0] cs_q;
   logic [OFF_W-1:0] ip_q;

   sfu_phase_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .fetch_done (fetch_done),
      .fetch_req  (fetch_req),
      .take_len   (take_len),
      .adv_en     (adv_en),
      .exec_en    (exec_en)
   );

   sfu_ptr_regs #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .LEN_W(LEN_W),
      .RST_SEG(RST_SEG), .RST_OFF(RST_OFF)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_len (take_len),
      .len_in   (fetch_len),
      .adv_en   (adv_en),
      .exec_en  (exec_en),
      .jmp_far  (jmp_far),
      .far_seg  (jmp_far_seg),
      .far_off  (jmp_far_off),
      .jmp_near (jmp_near),
      .near_off (jmp_near_off),
      .seg_q    (cs_q),
      .off_q    (ip_q)
   );

   sfu_phys_adder #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)
   ) u_add (
      .seg  (cs_q),
      .off  (ip_q),
      .phys (fetch_addr)
   );

   assign exec_valid = exec_en;
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned OFF_W     = 16,
   parameter int unsigned SEG_SHIFT = 4,
   parameter int unsigned LEN_W     = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [SEG_W+SEG_SHIFT-1:0] fetch_addr,
   input logic                       fetch_req,
   input logic                       fetch_done,
   input logic [LEN_W-1:0]           fetch_len,
   input logic                       exec_valid,
   input logic                       jmp_far,
   input logic [SEG_W-1:0]           jmp_far_seg,
   input logic [OFF_W-1:0]           jmp_far_off,
   input logic                       jmp_near,
   input logic [OFF_W-1:0]           jmp_near_off,
   input logic [SEG_W-1:0]           cs_q,
   input logic [OFF_W-1:0]           ip_q
);
   assert_adv_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && fetch_done) |=> (!fetch_req && !exec_valid));
   assert_exec_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_req && !exec_valid) |=> exec_valid);
   assert_back_to_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      exec_valid |=> fetch_req);
   assert_ip_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && fetch_done) |=> ##1
         (ip_q == OFF_W'($past(ip_q, 2) + OFF_W'($past(fetch_len, 2))) && $stable(cs_q)));
   assert_far_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && jmp_far) |=> (cs_q == $past(jmp_far_seg) && ip_q == $past(jmp_far_off)));
   assert_near_keeps_seg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && jmp_near && !jmp_far) |=> (cs_q == $past(cs_q) && ip_q == $past(jmp_near_off)));
   assert_far_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && jmp_near && jmp_far) |=> (ip_q == $past(jmp_far_off)));
   assert_fetch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_done) |=> (fetch_req && $stable(fetch_addr)));
endmodule

bind seg_fetch_unit sfu_checker #(
   .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .LEN_W(LEN_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_req(fetch_req),
   .fetch_done(fetch_done), .fetch_len(fetch_len), .exec_valid(exec_valid),
   .jmp_far(jmp_far), .jmp_far_seg(jmp_far_seg), .jmp_far_off(jmp_far_off),
   .jmp_near(jmp_near), .jmp_near_off(jmp_near_off), .cs_q(cs_q), .ip_q(ip_q)
);

// File: tb/seg_fetch_unit_test.sv
`timescale 1ns/1ps
module seg_fetch_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] fetch_addr;
   logic        fetch_req, exec_valid;
   logic        fetch_done = 1'b0;
   logic [3:0]  fetch_len = '0;
   logic        jmp_far = 1'b0, jmp_near = 1'b0;
   logic [15:0] jmp_far_seg = '0, jmp_far_off = '0, jmp_near_off = '0;

   int n_chk = 0, n_fail = 0;
   logic [19:0] exp_q[$];
   logic [15:0] m_cs = 16'h0FFF, m_ip = 16'h0010;
   bit seen = 1'b0, done = 1'b0;

   always #2.5 clk = ~clk;

   seg_fetch_unit #(.RST_SEG(16'h0FFF), .RST_OFF(16'h0010)) uut (
      .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_req(fetch_req),
      .fetch_done(fetch_done), .fetch_len(fetch_len), .exec_valid(exec_valid),
      .jmp_far(jmp_far), .jmp_far_seg(jmp_far_seg), .jmp_far_off(jmp_far_off),
      .jmp_near(jmp_near), .jmp_near_off(jmp_near_off)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [19:0] model_addr();
      return {m_cs, 4'h0} + {4'h0, m_ip};
   endfunction

   // monitor: compares first fetch-cycle address against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n) begin
            if (fetch_req && !seen) begin
               if (exp_q.size() == 0) check(1'b0, "R2 unexpected fetch", 32'(fetch_addr), 0);
               else begin
                  logic [19:0] e;
                  e = exp_q.pop_front();
                  check(fetch_addr == e, "R2/R4/R5/R6/R7/R9 fetch address", 32'(fetch_addr), 32'(e));
               end
            end
            seen = fetch_req;
         end
      end
   end

   // kind: 0 none, 1 far, 2 near, 3 far+near
   task automatic run_instr(input logic [3:0] len, input int kind, input logic [15:0] seg,
                            input logic [15:0] off, input logic [15:0] noff, input bit noise);
      while (!fetch_req) @(negedge clk);
      if (noise) begin
         jmp_far = 1'b1; jmp_far_seg = 16'hDEAD; jmp_far_off = 16'hBEEF;
         jmp_near = 1'b1; jmp_near_off = 16'h5555;
         @(negedge clk);
         jmp_far = 1'b0; jmp_near = 1'b0;
      end
      fetch_done = 1'b1; fetch_len = len;
      @(negedge clk);
      fetch_done = 1'b0;
      check(!fetch_req && !exec_valid, "R3 advance phase", {30'd0, fetch_req, exec_valid}, 0);
      if (noise) begin fetch_done = 1'b1; fetch_len = 4'hF; end // R8 ignored outside fetch
      @(negedge clk);
      fetch_done = 1'b0;
      check(exec_valid && !fetch_req, "R3 execute phase", {30'd0, fetch_req, exec_valid}, 1);
      m_ip = m_ip + {12'h0, len};
      jmp_far = (kind == 1 || kind == 3); jmp_far_seg = seg; jmp_far_off = off;
      jmp_near = (kind == 2 || kind == 3); jmp_near_off = noff;
      if (kind == 1 || kind == 3) begin m_cs = seg; m_ip = off; end
      else if (kind == 2) m_ip = noff;
      exp_q.push_back(model_addr());
      @(negedge clk);
      jmp_far = 1'b0; jmp_near = 1'b0;
      check(fetch_req, "R3 back to fetch", {31'd0, fetch_req}, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(fetch_req && !exec_valid, "R1 reset phase", {30'd0, fetch_req, exec_valid}, 2);
      check(fetch_addr == 20'h10000, "R1 reset address", 32'(fetch_addr), 32'h10000);
      exp_q.push_back(model_addr());
      rst_n = 1'b1;
      run_instr(4'd3, 0, 0, 0, 0, 0);                     // R9
      run_instr(4'd2, 1, 16'h2AE3, 16'h0003, 0, 0);       // R5 -> 2AE33
      run_instr(4'd1, 2, 0, 0, 16'h1234, 0);              // R6
      run_instr(4'd4, 0, 0, 0, 0, 1);                     // R8 noise
      run_instr(4'd1, 1, 16'h1000, 16'hFFFE, 0, 0);
      run_instr(4'd3, 0, 0, 0, 0, 0);                     // R4 wrap -> 10001
      run_instr(4'd2, 1, 16'hFFFF, 16'h0010, 0, 0);       // R2 wrap -> 00000
      run_instr(4'd0, 1, 16'hFFFF, 16'hFFFF, 0, 0);       // R2 -> 0FFEF
      run_instr(4'd5, 3, 16'h1234, 16'h0005, 16'hAAAA, 0);// R7 -> 12345
      run_instr(4'd15, 0, 0, 0, 0, 0);                    // R9 -> 12354
      run_instr(4'd2, 2, 0, 0, 16'h0000, 1);              // R6/R8
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
      check(fetch_addr == 20'h12340, "R6 final address", 32'(fetch_addr), 32'h12340);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule